// File: doc/BRIEF.md
# Peripheral Timer and Interrupt Register Bank

This block is the register bank of a general-purpose interface peripheral, reached by a processor over a small byte-wide bus. A 4-bit index selects one of sixteen byte registers. The bus has a chip select, a read strobe and a write strobe. Read data is driven combinationally from the selected register. Any side effect of a read or a write takes effect at the rising clock edge on which the strobe is high.

The bank holds two 16-bit down-counting timers, each with a reload latch, and seven plain byte registers: two port data registers, two direction registers, a shift register, an auxiliary control register and a peripheral control register. It also holds a 7-bit interrupt flag register and a 7-bit interrupt enable register. Each timer counts down once per clock and raises its own flag when it wraps through zero. Flags are cleared in three ways: by writing ones to the flag register, by reloading a timer, or by reading the low counter byte of a timer.

The active-high interrupt output combines the flags with the enables. The serial behaviour of the shift register, handshake lines and pin electrics are not modelled.

Top module: `vtimer_regs`

## Requirements
- R1: While reset is low, and immediately after it is released, the register values are as follows. Indices 0, 1, 2, 3, 10, 11 and 12 read 0x00. The flag register (index 13) reads 0x00. The enable register (index 14) reads 0x80. Both latch bytes of timer A (indices 6 and 7) read 0xFF. Both counters hold 0xFFFF. irq is 0.
- R2: Indices 0, 1, 2, 3, 10, 11 and 12 are plain byte registers that read back the last value written to them. Index 15 is a second name for index 1 on both read and write.
- R3: A write to index 4 or index 6 changes only the low byte of the timer A latch, and a write to index 7 changes only its high byte. None of these writes touches the counter or the flags. Reads of index 6 and 7 return the latch low and high bytes with no side effect.
- R4: A write to index 5 does three things on the same edge. It sets the timer A latch high byte. It loads the counter with {written byte, latch low byte}. It clears flag bit 6. Indices 4 and 5 read the low and high bytes of the timer A counter.
- R5: For timer B, a write to index 8 sets the latch low byte. A write to index 9 sets the latch high byte, loads the counter from the full latch and clears flag bit 5. Indices 8 and 9 read the low and high bytes of the timer B counter.
- R6: On every clock edge without a load, each counter decrements by one. A counter that holds 0x0000 becomes 0xFFFF on the next edge, and that edge sets the timer's flag: bit 6 for timer A, bit 5 for timer B. A counter loaded with value L therefore raises its flag on the (L+1)-th edge after the load.
- R7: A read of index 4 clears flag bit 6, and a read of index 8 clears flag bit 5. Reads of index 5 and index 9 leave the flags unchanged.
- R8: A write to index 13 clears each flag bit 6..0 whose written bit is 1 and leaves the other bits unchanged.
- R9: A read of index 13 returns the flags in bits 6..0. Bit 7 is 1 exactly when some flag bit is set whose enable bit is also set.
- R10: A write to index 14 with bit 7 = 1 sets the enable bits given as ones in bits 6..0. With bit 7 = 0 it clears those bits instead. A read of index 14 returns the enables with bit 7 forced to 1.
- R11: irq is 1 exactly while some flag bit and its enable bit are both 1.
- R12: If a timer wraps on the same edge that clears its flag (a write to index 13 or a read of the low counter byte), the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select for bus accesses |
| rd | input | 1 | Read strobe; read side effects occur at the edge while cs and rd are high |
| wr | input | 1 | Write strobe; the write occurs at the edge while cs and wr are high |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the indexed register, combinational |
| irq | output | 1 | Active-high interrupt request |

## Verification
The collision that matters is a timer wrapping through zero on the very edge where the bus clears that timer's flag. The clear can come from a write of ones to the flag register or from a read of the timer's low counter byte. The bench provokes this collision in two steps. It first loads a timer with the value 2, then waits exactly two edges and issues the clearing access, so that the access lands on the wrap edge. Afterwards it inspects the flag register: the flag must read as set. As a control, the same clear is also issued one edge after a wrap, and there it must remove the flag.

// File: rtl/vtimer_pkg.sv
package vtimer_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int IDX_W   = 4;
  localparam int FLAG_W  = BYTE_W - 1;
  localparam int N_PLAIN = 7;
  localparam int N_TMR   = 2;

  // flag bit owned by each timer (decoded by software, so fixed)
  localparam int FLAG_TA = 6;
  localparam int FLAG_TB = 5;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [FLAG_W-1:0] flags_t;

  typedef enum logic [IDX_W-1:0] {
    IX_PORT_B  = 4'd0,
    IX_PORT_A  = 4'd1,
    IX_DIR_B   = 4'd2,
    IX_DIR_A   = 4'd3,
    IX_TA_CLO  = 4'd4,
    IX_TA_CHI  = 4'd5,
    IX_TA_LLO  = 4'd6,
    IX_TA_LHI  = 4'd7,
    IX_TB_LO   = 4'd8,
    IX_TB_HI   = 4'd9,
    IX_SHIFT   = 4'd10,
    IX_AUXCTL  = 4'd11,
    IX_PERCTL  = 4'd12,
    IX_FLAGS   = 4'd13,
    IX_ENABLE  = 4'd14,
    IX_PORT_A2 = 4'd15
  } reg_idx_e;

  // counter step: plain decrement, wrapping through zero
  function automatic word_t tmr_step(word_t cur);
    return cur - word_t'(1);
  endfunction

  // flag update: clears first, then new events (event wins)
  function automatic flags_t flag_next(flags_t cur, flags_t set, flags_t clr);
    return (cur & ~clr) | set;
  endfunction

  // enable update: bit 7 chooses set or clear of the marked bits
  function automatic flags_t enable_next(flags_t cur, byte_t wv);
    if (wv[BYTE_W-1]) return cur | wv[FLAG_W-1:0];
    else              return cur & ~wv[FLAG_W-1:0];
  endfunction

  // flag register view: summary bit on top
  function automatic byte_t flag_view(flags_t fl, flags_t en);
    return {|(fl & en), fl};
  endfunction

endpackage

// File: rtl/vtimer_plain.sv
module vtimer_plain
  import vtimer_pkg::*;
#(
  parameter int NSLOT = N_PLAIN,
  parameter int W     = BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOT-1:0]         we,
  input  logic [W-1:0]             wdata,
  output logic [NSLOT-1:0][W-1:0]  q
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)     q[s] <= '0;
      else if (we[s]) q[s] <= wdata;
    end
  end

endmodule

// File: rtl/vtimer_counter.sv
module vtimer_counter
  import vtimer_pkg::*;
#(
  parameter int HALF_W = BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lat_lo_we,
  input  logic                lat_hi_we,
  input  logic                load,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] latch,
  output logic [2*HALF_W-1:0] count,
  output logic                underflow
);

  localparam int FULL_W = 2 * HALF_W;

  // wrap event: counter at zero and not being reloaded this edge
  assign underflow = !load && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '1;
      count <= '1;
    end else begin
      if (lat_lo_we) latch[HALF_W-1:0]      <= wdata;
      if (lat_hi_we) latch[FULL_W-1:HALF_W] <= wdata;
      if (load) count <= {wdata, latch[HALF_W-1:0]};
      else      count <= FULL_W'(tmr_step(word_t'(count)));
    end
  end

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (count == '1));

  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !underflow) |=> (count == $past(count) - 1'b1));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == {$past(wdata), $past(latch[HALF_W-1:0])}));

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_lo_we && !lat_hi_we) |=> $stable(latch));

endmodule

// File: rtl/vtimer_irq.sv
module vtimer_irq
  import vtimer_pkg::*;
#(
  parameter int NF = FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic          en_we,
  input  logic [NF:0]   en_wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] en,
  output logic          irq
);

  logic [NF-1:0] pending;
  assign pending = flags & en;
  assign irq     = |pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
    end else begin
      flags <= flag_next(flags, set, clr);
      if (en_we) en <= enable_next(en, en_wdata);
    end
  end

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((flags & $past(clr & ~set)) == '0));

  p_en_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && en_wdata[NF]) |=> ((en & $past(en_wdata[NF-1:0])) == $past(en_wdata[NF-1:0])));

  p_en_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !en_wdata[NF]) |=> ((en & $past(en_wdata[NF-1:0])) == '0));

  p_flags_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0 && clr == '0) |=> $stable(flags));

endmodule

// File: rtl/vtimer_regs.sv
module vtimer_regs
  import vtimer_pkg::*;
#(
  parameter int ADDR_W = IDX_W,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int TW = 2 * DATA_W;
  localparam int NF = DATA_W - 1;

  logic wr_hit, rd_hit;
  assign wr_hit = cs && wr;
  assign rd_hit = cs && rd;

  // ---------------- plain registers ----------------
  logic [N_PLAIN-1:0]             plain_we;
  logic [N_PLAIN-1:0][DATA_W-1:0] plain_q;

  always_comb begin
    plain_we = '0;
    if (wr_hit) begin
      case (addr)
        IX_PORT_B:             plain_we[0] = 1'b1;
        IX_PORT_A, IX_PORT_A2: plain_we[1] = 1'b1;
        IX_DIR_B:              plain_we[2] = 1'b1;
        IX_DIR_A:              plain_we[3] = 1'b1;
        IX_SHIFT:              plain_we[4] = 1'b1;
        IX_AUXCTL:             plain_we[5] = 1'b1;
        IX_PERCTL:             plain_we[6] = 1'b1;
        default:               plain_we    = '0;
      endcase
    end
  end

  vtimer_plain #(.NSLOT(N_PLAIN), .W(DATA_W)) u_plain (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (plain_we),
    .wdata (wdata),
    .q     (plain_q)
  );

  // ---------------- timers ----------------
  logic [N_TMR-1:0]  t_lo_we, t_hi_we, t_load, t_uf;
  logic [TW-1:0]     t_latch [N_TMR];
  logic [TW-1:0]     t_count [N_TMR];

  always_comb begin
    t_lo_we = '0;
    t_hi_we = '0;
    t_load  = '0;
    if (wr_hit) begin
      case (addr)
        IX_TA_CLO, IX_TA_LLO: t_lo_we[0] = 1'b1;
        IX_TA_CHI: begin
          t_hi_we[0] = 1'b1;
          t_load[0]  = 1'b1;
        end
        IX_TA_LHI:            t_hi_we[0] = 1'b1;
        IX_TB_LO:             t_lo_we[1] = 1'b1;
        IX_TB_HI: begin
          t_hi_we[1] = 1'b1;
          t_load[1]  = 1'b1;
        end
        default: t_load = '0;
      endcase
    end
  end

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    vtimer_counter #(.HALF_W(DATA_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat_lo_we (t_lo_we[t]),
      .lat_hi_we (t_hi_we[t]),
      .load      (t_load[t]),
      .wdata     (wdata),
      .latch     (t_latch[t]),
      .count     (t_count[t]),
      .underflow (t_uf[t])
    );
  end

  // ---------------- interrupt flags ----------------
  logic [NF-1:0] fl_set, fl_clr, fl_q, en_q;
  logic          en_we;
  logic          rd_ta_lo, rd_tb_lo;

  assign rd_ta_lo = rd_hit && (addr == IX_TA_CLO);
  assign rd_tb_lo = rd_hit && (addr == IX_TB_LO);
  assign en_we    = wr_hit && (addr == IX_ENABLE);

  always_comb begin
    fl_set          = '0;
    fl_set[FLAG_TA] = t_uf[0];
    fl_set[FLAG_TB] = t_uf[1];
    fl_clr          = '0;
    if (wr_hit && addr == IX_FLAGS) fl_clr = wdata[NF-1:0];
    if (rd_ta_lo || t_load[0]) fl_clr[FLAG_TA] = 1'b1;
    if (rd_tb_lo || t_load[1]) fl_clr[FLAG_TB] = 1'b1;
  end

  vtimer_irq #(.NF(NF)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (fl_set),
    .clr      (fl_clr),
    .en_we    (en_we),
    .en_wdata (wdata),
    .flags    (fl_q),
    .en       (en_q),
    .irq      (irq)
  );

  // ---------------- read mux ----------------
  always_comb begin
    case (addr)
      IX_PORT_B:             rdata = plain_q[0];
      IX_PORT_A, IX_PORT_A2: rdata = plain_q[1];
      IX_DIR_B:              rdata = plain_q[2];
      IX_DIR_A:              rdata = plain_q[3];
      IX_TA_CLO:             rdata = t_count[0][DATA_W-1:0];
      IX_TA_CHI:             rdata = t_count[0][TW-1:DATA_W];
      IX_TA_LLO:             rdata = t_latch[0][DATA_W-1:0];
      IX_TA_LHI:             rdata = t_latch[0][TW-1:DATA_W];
      IX_TB_LO:              rdata = t_count[1][DATA_W-1:0];
      IX_TB_HI:              rdata = t_count[1][TW-1:DATA_W];
      IX_SHIFT:              rdata = plain_q[4];
      IX_AUXCTL:             rdata = plain_q[5];
      IX_PERCTL:             rdata = plain_q[6];
      IX_FLAGS:              rdata = flag_view(fl_q, en_q);
      IX_ENABLE:             rdata = {1'b1, en_q};
      default:               rdata = '0;
    endcase
  end

  p_rdclr_ta_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ta_lo && !t_uf[0]) |=> !fl_q[FLAG_TA]);

  p_rdclr_tb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tb_lo && !t_uf[1]) |=> !fl_q[FLAG_TB]);

  p_uf_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t_uf[0] |=> fl_q[FLAG_TA]);

  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

endmodule

// File: tb/vtimer_regs_tb.sv
`timescale 1ns/100ps
module vtimer_regs_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vtimer_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic rd_edge(input logic [3:0] a);
    cs = 1; rd = 1; addr = a;
    @(posedge clk); @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    cs = 1; rd = 1; addr = a;
    #0.2;
    v = rdata;
    cs = 0; rd = 0;
    #0.1;
  endtask

  task automatic load_ta(input logic [15:0] v);
    wr_reg(4'd6, v[7:0]);
    wr_reg(4'd5, v[15:8]);
  endtask

  task automatic load_tb(input logic [15:0] v);
    wr_reg(4'd8, v[7:0]);
    wr_reg(4'd9, v[15:8]);
  endtask

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v, lo, hi;
    logic [15:0] exp;
    logic [3:0]  plain_idx [7];
    plain_idx = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd10, 4'd11, 4'd12};

    repeat (3) @(negedge clk);
    // R1: reset state, sampled while reset is still low
    for (int i = 0; i < 7; i++) begin
      peek(plain_idx[i], v); chk("R1 plain", v, 8'h00);
    end
    peek(4'd13, v); chk("R1 flags", v, 8'h00);
    peek(4'd14, v); chk("R1 enable", v, 8'h80);
    peek(4'd6, v);  chk("R1 latch lo", v, 8'hFF);
    peek(4'd7, v);  chk("R1 latch hi", v, 8'hFF);
    peek(4'd5, v);  chk("R1 count A hi", v, 8'hFF);
    peek(4'd9, v);  chk("R1 count B hi", v, 8'hFF);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;

    // keep timer B far from zero for now
    load_tb(16'h8000);

    // R2: plain registers and alias
    for (int i = 0; i < 7; i++) begin
      wr_reg(plain_idx[i], 8'h3C ^ 8'(i * 17));
    end
    for (int i = 0; i < 7; i++) begin
      peek(plain_idx[i], v); chk("R2 readback", v, 8'h3C ^ 8'(i * 17));
    end
    wr_reg(4'd15, 8'hA7);
    peek(4'd1, v);  chk("R2 alias write", v, 8'hA7);
    peek(4'd15, v); chk("R2 alias read", v, 8'hA7);

    // R3/R4: latch bytes versus counter
    load_ta(16'h4080);
    peek(4'd4, v); chk("R4 count lo after load", v, 8'h80);
    peek(4'd5, v); chk("R4 count hi after load", v, 8'h40);
    wr_reg(4'd7, 8'h12);
    peek(4'd4, v); chk("R3 count lo after idx7", v, 8'h7F);
    peek(4'd5, v); chk("R3 count hi after idx7", v, 8'h40);
    peek(4'd7, v); chk("R3 latch hi", v, 8'h12);
    wr_reg(4'd4, 8'h56);
    peek(4'd4, v); chk("R3 count lo after idx4", v, 8'h7E);
    peek(4'd6, v); chk("R3 latch lo via idx4", v, 8'h56);
    wr_reg(4'd6, 8'h9A);
    peek(4'd4, v); chk("R3 count lo after idx6", v, 8'h7D);
    peek(4'd6, v); chk("R3 latch lo via idx6", v, 8'h9A);
    peek(4'd7, v); chk("R3 latch hi kept", v, 8'h12);

    // R6/R11: load values, count down, wrap
    wr_reg(4'd14, 8'hC0);
    begin
      logic [15:0] vals [6];
      vals = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100, 16'h1234, 16'hFFFF};
      for (int n = 0; n < 6; n++) begin
        load_ta(vals[n]);
        for (int k = 0; k <= 3; k++) begin
          if (k > 0) @(negedge clk);
          exp = vals[n] - 16'(k);
          peek(4'd4, lo); peek(4'd5, hi);
          chk("R6 count value", {hi, lo}, exp);
          chk("R11 irq after wrap", irq, (32'(k) >= 32'(vals[n]) + 1) ? 1 : 0);
        end
      end
    end
    for (int n = 0; n <= 24; n++) begin
      load_ta(16'(n));
      for (int k = 1; k <= n + 1; k++) begin
        @(negedge clk);
        chk("R6 timer A wrap edge", irq, (k == n + 1) ? 1 : 0);
      end
    end

    // R7: read side effects on timer A flag
    peek(4'd13, v); chk("R7 flag6 set before read", v[6], 1);
    rd_edge(4'd5);
    peek(4'd13, v); chk("R7 idx5 read keeps flag", v[6], 1);
    rd_edge(4'd4);
    peek(4'd13, v); chk("R7 idx4 read clears flag", v[6], 0);
    chk("R11 irq low after clear", irq, 0);

    // R5/R6: timer B sweep
    wr_reg(4'd14, 8'h40);
    wr_reg(4'd14, 8'hA0);
    for (int n = 0; n <= 12; n++) begin
      load_tb(16'(n) | 16'h0000);
      peek(4'd8, lo); peek(4'd9, hi);
      chk("R5 timer B count after load", {hi, lo}, 16'(n));
      for (int k = 1; k <= n + 1; k++) begin
        @(negedge clk);
        peek(4'd13, v);
        chk("R6 timer B flag", v[5], (k == n + 1) ? 1 : 0);
      end
    end
    wr_reg(4'd8, 8'h21);
    wr_reg(4'd9, 8'h43);
    peek(4'd8, lo); peek(4'd9, hi);
    chk("R5 timer B load full latch", {hi, lo}, 16'h4321);
    peek(4'd13, v); chk("R5 idx9 write clears flag5", v[5], 0);
    load_tb(16'h0000);
    @(negedge clk);
    rd_edge(4'd9);
    peek(4'd13, v); chk("R7 idx9 read keeps flag5", v[5], 1);
    rd_edge(4'd8);
    peek(4'd13, v); chk("R7 idx8 read clears flag5", v[5], 0);

    // R8/R9: write-one-to-clear and summary bit
    wr_reg(4'd14, 8'h7F);
    wr_reg(4'd14, 8'hE0);
    wr_reg(4'd6, 8'h00);
    wr_reg(4'd5, 8'h00);
    wr_reg(4'd8, 8'h00);
    wr_reg(4'd9, 8'h00);
    @(negedge clk);
    peek(4'd13, v); chk("R9 both flags with summary", v, 8'hE0);
    wr_reg(4'd13, 8'h20);
    peek(4'd13, v); chk("R8 clear bit5 only", v, 8'hC0);
    wr_reg(4'd13, 8'h00);
    peek(4'd13, v); chk("R8 zero write no effect", v, 8'hC0);
    wr_reg(4'd13, 8'h9F);
    peek(4'd13, v); chk("R8 other bits no effect", v, 8'hC0);
    wr_reg(4'd14, 8'h40);
    peek(4'd13, v); chk("R9 summary off when not enabled", v, 8'h40);
    chk("R11 irq off when not enabled", irq, 0);
    peek(4'd14, v); chk("R10 clear enable bit", v, 8'hA0);
    wr_reg(4'd14, 8'hC0);
    peek(4'd13, v); chk("R9 summary on", v, 8'hC0);
    chk("R11 irq on", irq, 1);
    wr_reg(4'd14, 8'h83);
    peek(4'd14, v); chk("R10 set merges", v, 8'hE3);
    wr_reg(4'd14, 8'h03);
    peek(4'd14, v); chk("R10 clear marked", v, 8'hE0);
    wr_reg(4'd14, 8'h7F);
    peek(4'd14, v); chk("R10 clear all reads bit7", v, 8'h80);
    chk("R11 irq off with enables clear", irq, 0);
    wr_reg(4'd13, 8'h40);
    peek(4'd13, v); chk("R8 clear bit6", v, 8'h00);

    // R12: wrap collides with clear
    load_ta(16'h0002);
    repeat (2) @(negedge clk);
    wr_reg(4'd13, 8'h40);
    peek(4'd13, v); chk("R12 write-clear on wrap edge", v[6], 1);
    wr_reg(4'd13, 8'h40);
    peek(4'd13, v); chk("R8 clear after wrap edge", v[6], 0);
    load_ta(16'h0002);
    repeat (2) @(negedge clk);
    rd_edge(4'd4);
    peek(4'd13, v); chk("R12 read-clear on wrap edge", v[6], 1);
    load_tb(16'h0002);
    repeat (2) @(negedge clk);
    wr_reg(4'd13, 8'h20);
    peek(4'd13, v); chk("R12 timer B write-clear on wrap", v[5], 1);
    load_tb(16'h0002);
    repeat (2) @(negedge clk);
    rd_edge(4'd8);
    peek(4'd13, v); chk("R12 timer B read-clear on wrap", v[5], 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule